// File: doc/BRIEF.md
# Dual-Mode Parallel-to-Serial Transmitter

This block takes transmit words from a protocol device and sends them out one bit at a time on a serial line. A single bit-rate clock drives everything. An internal modulo counter divides that clock by the word width and so produces the word-rate reference phase. The device uses this phase to present its data. The reference phase is high for the first half of every word period and low for the second half.

The block has two lane modes. In full-width mode the device presents a whole 10-bit word once per word period. In half-width mode the device presents a 5-bit nibble on each half of the reference period. The nibble taken in the high phase becomes the upper half of the word. A word is loaded into the shift register only at the word boundary, and the bit at index 0 goes out first.

A loopback control does two things: it routes the serial stream to an internal receive-side pin and it drops the external output enable. A global enable can also force the external output enable off.

Top module: `ser_tx_dual`

## Requirements
- R1: After reset the bit counter starts at count 0. It advances by one on each clock and wraps from 9 to 0. `ref_phase` is high during counts 0..4 and low during counts 5..9.
- R2: With `mode_half` = 0, all ten bits of `tx_word` are captured on the clock edge that ends count 0.
- R3: With `mode_half` = 1, `tx_word[4:0]` is captured as word bits 9:5 on the edge that ends count 0. `tx_word[4:0]` is captured as word bits 4:0 on the edge that ends count 5. `tx_word[9:5]` has no effect in this mode.
- R4: The assembled word is loaded on the edge that ends count 9. `ser_out` then carries word bit k during count k of the next period, with bit 0 first.
- R5: A change on `tx_word` on any edge other than the capture edges of the current mode does not alter the bits that are sent.
- R6: With `loop_en` = 1, `loop_ser` equals `ser_out` and `ser_oe` is 0.
- R7: With `loop_en` = 0, `loop_ser` is 0 and `ser_oe` equals `chip_en`.
- R8: With `chip_en` = 0, `ser_oe` is 0 whatever the other inputs are.
- R9: While `rst_n` is low, `ser_out` and `loop_ser` are 0 and `ref_phase` is 1. The first word period after release sends all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_half | input | 1 | 0 = full-width 10-bit lane, 1 = half-width 5-bit lane |
| tx_word | input | 10 | Parallel transmit data; only bits 4:0 are used in half-width mode |
| loop_en | input | 1 | Route the serial stream to `loop_ser` and disable the external output |
| chip_en | input | 1 | Global enable for the external serial output |
| ser_out | output | 1 | Serial data, bit 0 of each word first |
| ser_oe | output | 1 | External serial output enable (0 = high impedance) |
| loop_ser | output | 1 | Internal loopback serial stream toward the receiver |
| ref_phase | output | 1 | Word-rate reference phase: high in the first half of each word |

## Verification
A counter that slips or wraps at the wrong count shows up on `ref_phase` within one word period. It also misaligns every later word on `ser_out`. A capture made at the wrong count, or into the wrong half in half-width mode, shows up as wrong serial bits in the word period after that capture. So any capture fault reaches the pins at most 19 clocks after the stimulus that exposes it. Faults in the output enable or loopback gating are combinational, so they appear in the same cycle as the control change.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic {
      LANE_FULL = 1'b0,
      LANE_HALF = 1'b1
   } lane_mode_e;
endpackage

// File: rtl/sertx_phase_ctr.sv
module sertx_phase_ctr #(
   parameter int WORD_W = 10,
   localparam int CNT_W = $clog2(WORD_W),
   localparam int HALF_W = WORD_W / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o,
   output logic             first_o,
   output logic             mid_o,
   output logic             last_o,
   output logic             hi_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (last_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o   = cnt_q;
   assign first_o = (cnt_q == '0);
   assign mid_o   = (cnt_q == CNT_W'(HALF_W));
   assign last_o  = (cnt_q == CNT_W'(WORD_W - 1));
   assign hi_o    = (cnt_q < CNT_W'(HALF_W));
endmodule

// File: rtl/sertx_word_asm.sv
module sertx_word_asm
   import sertx_pkg::*;
#(
   parameter int WORD_W = 10,
   parameter bit HALF_EN = 1'b1,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_i,
   input  logic              mid_i,
   input  logic              half_i,
   input  logic [WORD_W-1:0] data_i,
   output logic [WORD_W-1:0] hold_o
);
   lane_mode_e mode;
   assign mode = lane_mode_e'(half_i);

   generate
      if (HALF_EN) begin : g_dual
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_o <= '0;
            end else if (first_i) begin
               if (mode == LANE_HALF) hold_o[WORD_W-1:HALF_W] <= data_i[HALF_W-1:0];
               else                   hold_o <= data_i;
            end else if (mid_i && mode == LANE_HALF) begin
               hold_o[HALF_W-1:0] <= data_i[HALF_W-1:0];
            end
         end
      end else begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hold_o <= '0;
            else if (first_i) hold_o <= data_i;
         end
      end
   endgenerate
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
   parameter int WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] sh_o,
   output logic              bit_o
);
   logic [WORD_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh_q <= '0;
      else if (load_i) sh_q <= word_i;
      else             sh_q <= {1'b0, sh_q[WORD_W-1:1]};
   end

   assign sh_o  = sh_q;
   assign bit_o = sh_q[0];
endmodule

// File: rtl/ser_tx_dual.sv
module ser_tx_dual #(
   parameter int WORD_W = 10,
   parameter bit HALF_EN = 1'b1,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_half,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              loop_en,
   input  logic              chip_en,
   output logic              ser_out,
   output logic              ser_oe,
   output logic              loop_ser,
   output logic              ref_phase
);
   generate
      if (WORD_W < 2 || (WORD_W % 2) != 0) begin : g_bad_width
         $error("ser_tx_dual: WORD_W must be even and at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic              at_first, at_mid, at_last;
   logic [WORD_W-1:0] hold_q;
   logic [WORD_W-1:0] sh_q;
   logic              line_bit;

   sertx_phase_ctr #(.WORD_W(WORD_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .cnt_o(cnt_q), .first_o(at_first),
      .mid_o(at_mid), .last_o(at_last), .hi_o(ref_phase)
   );

   sertx_word_asm #(.WORD_W(WORD_W), .HALF_EN(HALF_EN)) u_asm (
      .clk(clk), .rst_n(rst_n), .first_i(at_first), .mid_i(at_mid),
      .half_i(mode_half), .data_i(tx_word), .hold_o(hold_q)
   );

   sertx_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(at_last), .word_i(hold_q),
      .sh_o(sh_q), .bit_o(line_bit)
   );

   assign ser_out  = line_bit;
   assign loop_ser = loop_en & line_bit;
   assign ser_oe   = chip_en & ~loop_en;
endmodule

// File: rtl/ser_tx_dual_chk.sv
module ser_tx_dual_chk #(
   parameter int WORD_W = 10,
   localparam int CNT_W = $clog2(WORD_W),
   localparam int HALF_W = WORD_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_half,
   input logic [WORD_W-1:0] tx_word,
   input logic              loop_en,
   input logic              chip_en,
   input logic              ser_out,
   input logic              ser_oe,
   input logic              loop_ser,
   input logic [CNT_W-1:0]  cnt,
   input logic [WORD_W-1:0] hold,
   input logic [WORD_W-1:0] sh
);
   assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(WORD_W - 1)) |=> (cnt == '0));

   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != CNT_W'(WORD_W - 1)) |=> (cnt == $past(cnt) + 1'b1));

   assert_full_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_half && cnt == '0) |=> (hold == $past(tx_word)));

   assert_low_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_half && cnt == CNT_W'(HALF_W))
      |=> (hold[HALF_W-1:0] == $past(tx_word[HALF_W-1:0])) && $stable(hold[WORD_W-1:HALF_W]));

   assert_hold_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && cnt != CNT_W'(HALF_W)) |=> $stable(hold));

   assert_shift_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != CNT_W'(WORD_W - 1)) |=> (ser_out == $past(sh[1])));

   assert_loop_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> (loop_ser == ser_out) && !ser_oe);

   assert_no_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_en |-> !loop_ser);

   assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |-> !ser_oe);
endmodule

bind ser_tx_dual ser_tx_dual_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_half(mode_half), .tx_word(tx_word),
   .loop_en(loop_en), .chip_en(chip_en), .ser_out(ser_out), .ser_oe(ser_oe),
   .loop_ser(loop_ser), .cnt(cnt_q), .hold(hold_q), .sh(sh_q)
);

// File: tb/test_ser_tx_dual.sv
module test_ser_tx_dual;
   localparam int W  = 10;
   localparam int HW = W / 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode_half = 1'b0;
   logic [W-1:0] tx_word = '0;
   logic         loop_en = 1'b0;
   logic         chip_en = 1'b1;
   logic         ser_out, ser_oe, loop_ser, ref_phase;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string tag = "R9";

   // behavioural reference state
   int     m_cnt = 0;
   bit     m_word[W];
   bit     m_q[$];
   bit     m_ser = 1'b0;

   ser_tx_dual i_ser_tx_dual (
      .clk(clk), .rst_n(rst_n), .mode_half(mode_half), .tx_word(tx_word),
      .loop_en(loop_en), .chip_en(chip_en), .ser_out(ser_out), .ser_oe(ser_oe),
      .loop_ser(loop_ser), .ref_phase(ref_phase)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   initial begin
      for (int i = 0; i < W; i++) m_word[i] = 1'b0;
      for (int i = 0; i < W - 1; i++) m_q.push_back(1'b0);
   end

   // reference model: updated on every active edge after reset release
   always @(posedge clk) begin
      if (rst_n) begin
         if (m_cnt == 0) begin
            if (mode_half) for (int i = 0; i < HW; i++) m_word[HW + i] = tx_word[i];
            else           for (int i = 0; i < W; i++)  m_word[i] = tx_word[i];
         end else if (m_cnt == HW && mode_half) begin
            for (int i = 0; i < HW; i++) m_word[i] = tx_word[i];
         end
         if (m_cnt == W - 1) for (int i = 0; i < W; i++) m_q.push_back(m_word[i]);
         m_ser = m_q.pop_front();
         m_cnt = (m_cnt == W - 1) ? 0 : m_cnt + 1;
      end
   end

   // compare a quarter period after each edge, away from input changes
   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         check("R1", "ref_phase", int'(ref_phase), int'(m_cnt < HW));
         check(tag, "ser_out", int'(ser_out), int'(m_ser));
         if (loop_en) begin
            check("R6", "loop_ser", int'(loop_ser), int'(m_ser));
            check("R6", "ser_oe", int'(ser_oe), 0);
         end else begin
            check("R7", "loop_ser", int'(loop_ser), 0);
            if (chip_en) check("R7", "ser_oe", int'(ser_oe), 1);
            else         check("R8", "ser_oe", int'(ser_oe), 0);
         end
      end
   end

   task automatic run(input int n, input int kind);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tx_word = W'($urandom);
         case (kind)
            1: begin loop_en = 1'b1; end
            2: begin chip_en = 1'b0; loop_en = 1'($urandom); end
            3: begin
               if ($urandom_range(0, 30) == 0) mode_half = ~mode_half;
               loop_en = ($urandom_range(0, 7) == 0);
               chip_en = ($urandom_range(0, 5) != 0);
            end
            default: ;
         endcase
      end
   endtask

   initial begin
      loop_en = 1'b1;
      tx_word = '1;
      repeat (3) @(negedge clk);
      #5;
      check("R9", "ser_out in reset", int'(ser_out), 0);
      check("R9", "loop_ser in reset", int'(loop_ser), 0);
      check("R9", "ref_phase in reset", int'(ref_phase), 1);
      @(negedge clk);
      loop_en = 1'b0;
      tag = "R9";
      rst_n = 1'b1;
      repeat (W - 1) @(negedge clk);          // first period sends zeros
      tag = "R2 R4 R5";
      mode_half = 1'b0; chip_en = 1'b1; loop_en = 1'b0;
      run(400, 0);
      tag = "R3 R5";
      mode_half = 1'b1;
      run(400, 0);
      tag = "R6 R4";
      run(200, 1);
      loop_en = 1'b0;
      tag = "R8 R4";
      run(120, 2);
      chip_en = 1'b1;
      tag = "R2 R3 R5";
      run(1500, 3);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule